// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel that sits beside a free-running 16-bit timer counter. It watches the counter value supplied on its input. When that value equals the channel's active compare value while the timer is running, the channel drives its output pin according to a three-bit mode field. It also raises its own channel flag and a flag shared by all channels of the timer. The pin comes straight from a flip-flop, so it never glitches.

Software loads the 16-bit compare value in two byte writes. The low byte waits in a holding register. The high-byte write combines it with the held low byte. Modes 1, 2 and 3 put the combined value to work at once. Every other mode parks it in a shadow register, and the active register picks it up the next time the running counter sits at zero. A parameter marks the instance that serves as channel 0 of its timer. On that instance, modes 6 and 7 are refused.

Top module: `oc_channel`

## Requirements
- R1: While reset is asserted, the output pin, both flags, the low-byte holding register, the shadow register and the active compare register are all zero.
- R2: A low-byte write (`wr_lo`) only updates the holding register. The active and shadow values stay as they were until a high-byte write (`wr_hi`) stores {`wr_data`, held low byte} into the shadow register. When both strobes arrive in the same cycle, the high-byte write uses the previously held low byte.
- R3: In modes 1, 2 and 3, a high-byte write also loads the combined value into the active register, so it is compared from the next cycle on.
- R4: In modes 0, 4, 5, 6 and 7, the active register takes the shadow value on each clock edge where `run` is high and `count` is 0x0000. A high-byte write in that same cycle only updates the shadow register.
- R5: A match is `run` high and `count` equal to the active value. On the next edge the pin is set in mode 0, cleared in mode 1 and inverted in mode 2. With `run` low, nothing matches.
- R6: In mode 3 a match sets the pin. When `run` is high and `count` is 0x0000 without a match, the pin is cleared. A match at zero sets the pin.
- R7: In modes 4 to 7 the pin keeps its value, but matches still set the flags.
- R8: A match sets `ch_flag` and `tmr_flag` on the next edge. Writing 1 to `clr_ch` or `clr_tmr` clears the corresponding flag. A match in the same cycle as a clear leaves the flag set.
- R9: `irq` is high exactly when `ch_flag` and `irq_mask` are both high.
- R10: With `LIMIT_MODES` set, modes 6 and 7 neither change the pin nor set either flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Timer running |
| count | input | 16 | Current timer counter value |
| mode | input | 3 | Compare mode (0 set, 1 clear, 2 toggle, 3 set / clear at zero, 4-7 hold) |
| wr_lo | input | 1 | Low compare byte write strobe |
| wr_hi | input | 1 | High compare byte write strobe |
| wr_data | input | 8 | Byte written by either strobe |
| clr_ch | input | 1 | Write-one-to-clear for the channel flag |
| clr_tmr | input | 1 | Write-one-to-clear for the shared timer flag |
| irq_mask | input | 1 | Channel interrupt enable |
| pin_out | output | 1 | Registered compare output |
| ch_flag | output | 1 | Channel match flag |
| tmr_flag | output | 1 | Shared timer match flag |
| irq | output | 1 | Interrupt request |

## Verification
The compare registers cannot be seen at the ports. A wrong active or shadow value only shows up as a match at the wrong counter value. That means a pin edge or a flag set one cycle after the bad count, or a missing one. A deferred load that happens too early or too late is exposed by the first counter pass through zero that follows. The bench therefore steps the counter through short periods with the compare values inside them and compares all four outputs of two instances with a behavioural model after every clock edge. A bad holding-register value is caught one full counter period after the high-byte write.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [2:0] {
        OC_SET      = 3'd0,
        OC_CLR      = 3'd1,
        OC_TGL      = 3'd2,
        OC_SET_ZCLR = 3'd3,
        OC_HOLD4    = 3'd4,
        OC_HOLD5    = 3'd5,
        OC_HOLD6    = 3'd6,
        OC_HOLD7    = 3'd7
    } oc_mode_e;

    // modes whose new compare value goes live right after the high-byte write
    function automatic logic oc_loads_now(input logic [2:0] m);
        return (m == OC_CLR) || (m == OC_TGL) || (m == OC_SET_ZCLR);
    endfunction

endpackage

// File: rtl/oc_byte_stage.sv
module oc_byte_stage #(
    parameter int BYTE_W = 8,
    localparam int VAL_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              val_stb,
    output logic [VAL_W-1:0]  val
);

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
    } stage_t;

    stage_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_lo) s_d.lo = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // the high byte pairs with the low byte held before this cycle
    assign val_stb = wr_hi;
    assign val     = {wr_data, s_q.lo};

endmodule

// File: rtl/oc_cmp_regs.sv
module oc_cmp_regs #(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             val_stb,
    input  logic [VAL_W-1:0] val,
    input  logic             load_now,
    input  logic             at_zero,
    output logic [VAL_W-1:0] active
);

    typedef struct packed {
        logic [VAL_W-1:0] shadow;
        logic [VAL_W-1:0] active;
    } cmp_t;

    cmp_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (at_zero) s_d.active = s_q.shadow;
        if (val_stb) begin
            s_d.shadow = val;
            if (load_now) s_d.active = val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active = s_q.active;

    // R2: without a high-byte write the shadow value cannot move
    a_r2_shadow_held: assert property (@(posedge clk) disable iff (!rst_n)
        !val_stb |=> $stable(s_q.shadow));

    // R3: immediate modes take the written value on the next edge
    a_r3_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (val_stb && load_now) |=> (active == $past(val)));

    // R4: deferred writes leave the active value alone unless the counter is at zero
    a_r4_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_now && !at_zero) |=> $stable(active));

endmodule

// File: rtl/oc_match_out.sv
module oc_match_out
    import oc_pkg::*;
#(
    parameter int   VAL_W       = 16,
    parameter logic LIMIT_MODES = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [VAL_W-1:0] count,
    input  logic [VAL_W-1:0] active,
    input  logic [2:0]       mode,
    input  logic             clr_ch,
    input  logic             clr_tmr,
    output logic             pin_o,
    output logic             ch_flag_o,
    output logic             tmr_flag_o
);

    typedef struct packed {
        logic pin;
        logic ch_flag;
        logic tmr_flag;
    } out_t;

    out_t s_d, s_q;
    logic allowed;
    logic hit;
    logic at_zero;

    generate
        if (LIMIT_MODES) begin : g_limited
            assign allowed = (mode != OC_HOLD6) && (mode != OC_HOLD7);
        end else begin : g_full
            assign allowed = 1'b1;
        end
    endgenerate

    assign hit     = run && (count == active) && allowed;
    assign at_zero = run && (count == '0);

    always_comb begin
        s_d = s_q;
        if (hit) begin
            unique case (mode)
                OC_SET, OC_SET_ZCLR: s_d.pin = 1'b1;
                OC_CLR:              s_d.pin = 1'b0;
                OC_TGL:              s_d.pin = ~s_q.pin;
                default:             s_d.pin = s_q.pin;
            endcase
        end else if (at_zero && mode == OC_SET_ZCLR) begin
            s_d.pin = 1'b0;
        end
        s_d.ch_flag  = (s_q.ch_flag  & ~clr_ch)  | hit;
        s_d.tmr_flag = (s_q.tmr_flag & ~clr_tmr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pin_o      = s_q.pin;
    assign ch_flag_o  = s_q.ch_flag;
    assign tmr_flag_o = s_q.tmr_flag;

    // R8: a match always leaves both flags set
    a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (ch_flag_o && tmr_flag_o));

    // R8: a clear without a match empties the channel flag
    a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ch && !hit) |=> !ch_flag_o);

    // R7: hold modes never move the pin
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode >= 3'd4) |=> $stable(pin_o));

    // R6: counter zero without a match clears the pin in mode 3
    a_r6_zero_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 && run && count == '0 && !hit) |=> !pin_o);

    // R10: refused modes raise no flag
    a_r10_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (LIMIT_MODES && mode >= 3'd6 && !ch_flag_o) |=> !ch_flag_o);

endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
#(
    parameter int   BYTE_W      = 8,
    parameter logic LIMIT_MODES = 1'b0,
    localparam int  VAL_W       = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [VAL_W-1:0]  count,
    input  logic [2:0]        mode,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              clr_ch,
    input  logic              clr_tmr,
    input  logic              irq_mask,
    output logic              pin_out,
    output logic              ch_flag,
    output logic              tmr_flag,
    output logic              irq
);

    logic             val_stb;
    logic [VAL_W-1:0] val;
    logic [VAL_W-1:0] active;
    logic             at_zero;
    logic             load_now;

    assign at_zero  = run && (count == '0);
    assign load_now = oc_loads_now(mode);

    oc_byte_stage #(.BYTE_W(BYTE_W)) i_byte_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .val_stb (val_stb),
        .val     (val)
    );

    oc_cmp_regs #(.VAL_W(VAL_W)) i_cmp_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .val_stb  (val_stb),
        .val      (val),
        .load_now (load_now),
        .at_zero  (at_zero),
        .active   (active)
    );

    oc_match_out #(.VAL_W(VAL_W), .LIMIT_MODES(LIMIT_MODES)) i_match_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .count      (count),
        .active     (active),
        .mode       (mode),
        .clr_ch     (clr_ch),
        .clr_tmr    (clr_tmr),
        .pin_o      (pin_out),
        .ch_flag_o  (ch_flag),
        .tmr_flag_o (tmr_flag)
    );

    // R9: request follows the registered channel flag and the mask
    assign irq = ch_flag & irq_mask;

    a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_mask |-> !irq);

endmodule

// File: tb/test_oc_channel.sv
module test_oc_channel;

    localparam int PER = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        run = 1'b0;
    logic [15:0] count = '0;
    logic [2:0]  mode = '0;
    logic        wr_lo = 1'b0;
    logic        wr_hi = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        clr_ch = 1'b0;
    logic        clr_tmr = 1'b0;
    logic        irq_mask = 1'b0;
    logic [1:0]  pin, chf, tmf, irqo;

    int    n_checks = 0;
    int    n_errors = 0;
    string phase = "R1";
    bit    armed = 1'b0;

    always #5 clk = ~clk;

    oc_channel i_oc_channel (
        .clk(clk), .rst_n(rst_n), .run(run), .count(count), .mode(mode),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .clr_ch(clr_ch),
        .clr_tmr(clr_tmr), .irq_mask(irq_mask), .pin_out(pin[0]),
        .ch_flag(chf[0]), .tmr_flag(tmf[0]), .irq(irqo[0])
    );

    oc_channel #(.LIMIT_MODES(1'b1)) i_oc_channel_ch0 (
        .clk(clk), .rst_n(rst_n), .run(run), .count(count), .mode(mode),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .clr_ch(clr_ch),
        .clr_tmr(clr_tmr), .irq_mask(irq_mask), .pin_out(pin[1]),
        .ch_flag(chf[1]), .tmr_flag(tmf[1]), .irq(irqo[1])
    );

    // behavioural reference, index 1 is the restricted instance
    int m_lo [2];
    int m_shd[2];
    int m_act[2];
    bit m_pin[2];
    bit m_ch [2];
    bit m_tm [2];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                m_lo[k] <= 0; m_shd[k] <= 0; m_act[k] <= 0;
                m_pin[k] <= 0; m_ch[k] <= 0; m_tm[k] <= 0;
            end
        end else begin
            for (int k = 0; k < 2; k++) begin
                int  newv;
                int  nact;
                bit  ok, hit, zero;
                ok   = !(k == 1 && mode >= 6);
                hit  = run && (int'(count) == m_act[k]) && ok;
                zero = run && (count == 0);
                newv = int'(wr_data) * 256 + m_lo[k];
                nact = zero ? m_shd[k] : m_act[k];
                if (wr_hi && (mode >= 1 && mode <= 3)) nact = newv;
                m_act[k] <= nact;
                if (wr_hi) m_shd[k] <= newv;
                if (wr_lo) m_lo[k] <= int'(wr_data);
                if (hit) begin
                    if (mode == 0 || mode == 3) m_pin[k] <= 1'b1;
                    else if (mode == 1) m_pin[k] <= 1'b0;
                    else if (mode == 2) m_pin[k] <= !m_pin[k];
                end else if (zero && mode == 3) begin
                    m_pin[k] <= 1'b0;
                end
                m_ch[k] <= (m_ch[k] && !clr_ch) || hit;
                m_tm[k] <= (m_tm[k] && !clr_tmr) || hit;
            end
        end
    end

    always @(posedge clk) begin
        #3;
        if (armed) begin
            for (int k = 0; k < 2; k++) begin
                bit exp_irq;
                exp_irq = m_ch[k] && irq_mask;
                n_checks++;
                if (pin[k] !== m_pin[k] || chf[k] !== m_ch[k] ||
                    tmf[k] !== m_tm[k] || irqo[k] !== exp_irq) begin
                    n_errors++;
                    $display("FAIL %s inst%0d count=%0d: pin/ch/tmr/irq got %b%b%b%b exp %b%b%b%b",
                             phase, k, count, pin[k], chf[k], tmf[k], irqo[k],
                             m_pin[k], m_ch[k], m_tm[k], exp_irq);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin
            @(negedge clk);
            wr_lo = 1'b0; wr_hi = 1'b0; clr_ch = 1'b0; clr_tmr = 1'b0;
            if (run) count = 16'((int'(count) + 1) % PER);
        end
    endtask

    task automatic write16(input int v, input bit lo_only, input bit hi_only);
        if (!hi_only) begin
            wr_lo = 1'b1; wr_data = 8'(v); cyc(1);
        end
        if (!lo_only) begin
            wr_hi = 1'b1; wr_data = 8'(v >> 8); cyc(1);
        end
    endtask

    task automatic wait_count(input int c);
        while (int'(count) != c) cyc(1);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        armed = 1'b1;
        phase = "R1";
        @(negedge clk);
        n_checks++;
        if (pin !== 2'b00 || chf !== 2'b00 || tmf !== 2'b00) begin
            n_errors++;
            $display("FAIL R1 reset outputs got %b %b %b exp 00 00 00", pin, chf, tmf);
        end
        cyc(2);
        rst_n = 1'b1;
        cyc(2);

        phase = "R2";
        mode = 3'd2;
        write16(16'h0005, 1'b1, 1'b0);
        run = 1'b1;
        cyc(2 * PER);
        write16(16'h0000, 1'b0, 1'b1);
        cyc(2 * PER);
        wr_lo = 1'b1; wr_hi = 1'b1; wr_data = 8'h09;
        cyc(1);
        cyc(PER);
        write16(16'h0900, 1'b0, 1'b1);
        cyc(2 * PER);

        phase = "R3";
        mode = 3'd1;
        write16(16'h0003, 1'b0, 1'b0);
        cyc(2 * PER);
        mode = 3'd2;
        wait_count(6);
        write16(16'h0008, 1'b0, 1'b0);
        cyc(2 * PER);

        phase = "R4";
        mode = 3'd0;
        clr_ch = 1'b1; clr_tmr = 1'b1; cyc(1);
        write16(16'h000A, 1'b0, 1'b0);
        cyc(2 * PER);
        wait_count(PER - 1);
        wr_hi = 1'b0; wr_lo = 1'b1; wr_data = 8'h02; cyc(1);
        wr_hi = 1'b1; wr_data = 8'h00; cyc(1);
        cyc(2 * PER);

        phase = "R5";
        mode = 3'd2;
        run = 1'b0;
        count = 16'd2;
        clr_ch = 1'b1; clr_tmr = 1'b1; cyc(1);
        cyc(5);
        run = 1'b1;
        cyc(2 * PER);

        phase = "R6";
        mode = 3'd3;
        write16(16'h0004, 1'b0, 1'b0);
        cyc(3 * PER);
        write16(16'h0000, 1'b0, 1'b0);
        cyc(2 * PER);

        phase = "R7";
        mode = 3'd5;
        write16(16'h0007, 1'b0, 1'b0);
        clr_ch = 1'b1; clr_tmr = 1'b1; cyc(1);
        cyc(3 * PER);

        phase = "R10";
        clr_ch = 1'b1; clr_tmr = 1'b1; cyc(1);
        mode = 3'd6;
        cyc(2 * PER);
        mode = 3'd7;
        cyc(2 * PER);

        phase = "R8";
        mode = 3'd2;
        wait_count(5);
        clr_ch = 1'b1; clr_tmr = 1'b1; cyc(1);
        cyc(3);
        wait_count(7);
        clr_ch = 1'b1; cyc(1);
        cyc(3);
        clr_tmr = 1'b1; cyc(1);
        cyc(PER);

        phase = "R9";
        irq_mask = 1'b1;
        cyc(PER);
        clr_ch = 1'b1; cyc(1);
        cyc(3);
        irq_mask = 1'b0;
        cyc(PER);
        irq_mask = 1'b1;
        cyc(PER);

        phase = "R1";
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        run = 1'b0;
        cyc(3);

        armed = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog in phase %s: got hung run exp completion", phase);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule